// File: doc/BRIEF.md
# Software Standby Power Controller

This controller decides when a small microcontroller core may drop into a deep sleep state with its clocks stopped, and how it comes back out. When the core signals that it has executed its sleep instruction, the controller checks three configuration bits. If all three hold the required values, it turns off the CPU clock, the peripheral clock and the oscillator enable. It also raises a flag telling the serial, PWM and analog-converter units that their state will not survive the sleep.

Three kinds of event end the sleep. An interrupt request (non-maskable, per-line enabled IRQ, key-input or wake-event lines, or the keyboard interrupt) restarts the oscillator. After a stabilization delay picked by a 3-bit select, the controller raises a one-cycle interrupt-handling request. The reset pin restores all clocks at once and holds the core in reset until the pin is released. The hardware-standby pin overrides everything and parks the controller in a hardware standby state. A status output records the source that was accepted.

States: RUN, SW_STANDBY, OSC_WAIT, WAKE_IRQ, RESET_WAIT, HW_STANDBY. Transitions:

| From | To | Condition |
|------|----|-----------|
| RUN | SW_STANDBY | sleep strobe with the three entry bits set correctly |
| SW_STANDBY | OSC_WAIT | qualified interrupt wake |
| OSC_WAIT | WAKE_IRQ | counter reaches zero |
| WAKE_IRQ | RUN | always |
| RESET_WAIT | RUN | reset pin high |
| HW_STANDBY | RESET_WAIT | standby pin high |
| any | RESET_WAIT | reset pin low (standby pin high) |
| any | HW_STANDBY | standby pin low |

Top module: `stby_pwr_ctrl`

## Requirements
- R1: From RUN, standby is entered on the clock edge that samples `sleep_strobe`=1 only while `sel_standby`=1, `low_speed_on`=0 and `wdt_presc_sel`=0. Any other combination, or no strobe, leaves the block in RUN with all clocks enabled.
- R2: In SW_STANDBY, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0. In RUN all three are 1.
- R3: `unretained_rst` is 1 in SW_STANDBY, OSC_WAIT, RESET_WAIT and HW_STANDBY, and 0 in RUN and WAKE_IRQ.
- R4: An IRQ line wakes the block only when its request and its own `irq_en` bit are both 1 and `cpu_irq_mask` is 0. `nmi` wakes the block regardless of the mask.
- R5: A key-input or wake-event line wakes the block only when its request and its enable bit are both 1 and `cpu_irq_mask` is 0. `kbd_irq` wakes the block only when `cpu_irq_mask` is 0.
- R6: On the edge that accepts an interrupt wake, the block enters OSC_WAIT: `osc_en`=1, CPU and peripheral clocks stay 0. OSC_WAIT lasts N cycles. N is the value for `stab_sel` codes 0..7 (8192, 16384, 32768, 65536, 131072, 262144, 2048, 16) shifted right by `SCALE_SHIFT`, with a minimum of 1. The select is sampled on the accepting edge.
- R7: `irq_take` is 1 for exactly one cycle, the first cycle after OSC_WAIT. The block is in RUN on the next edge.
- R8: With `stby_pin_n`=1, `res_pin_n`=0 in any state other than HW_STANDBY moves the block to RESET_WAIT on the next edge. RESET_WAIT drives all three clock enables to 1 and `core_rst_hold`=1. It returns to RUN on the first edge that samples `res_pin_n`=1.
- R9: `stby_pin_n`=0 moves the block to HW_STANDBY on the next edge from any state, taking priority over the reset pin. HW_STANDBY drives all clocks to 0 and `hw_standby`=1. It goes to RESET_WAIT on the first edge with `stby_pin_n`=1.
- R10: `wake_src` is cleared to 0 on entering SW_STANDBY. It then records the accepted source: 1 NMI, 2 IRQ, 3 key input, 4 wake event, 5 keyboard, 6 reset pin (set on any entry to RESET_WAIT), 7 standby pin. Among simultaneous interrupts the priority is NMI, IRQ, key, wake event, keyboard.
- R11: A reset-pin or standby-pin event during OSC_WAIT aborts the wait and no `irq_take` pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | always-on controller clock |
| rst_n | input | 1 | asynchronous power-on reset, active low |
| sleep_strobe | input | 1 | one-cycle pulse when the sleep instruction executes |
| sel_standby | input | 1 | standby-select configuration bit |
| low_speed_on | input | 1 | low-speed mode bit, must be 0 to enter |
| wdt_presc_sel | input | 1 | watchdog prescaler-select bit, must be 0 to enter |
| stab_sel | input | 3 | stabilization-time select |
| cpu_irq_mask | input | 1 | global CPU interrupt mask |
| nmi | input | 1 | non-maskable interrupt request |
| irq_req | input | N_LINES | IRQ line requests |
| irq_en | input | N_LINES | per-line IRQ enables |
| key_in | input | N_LINES | key-input line requests |
| key_en | input | N_LINES | key-input enables |
| wke_in | input | N_LINES | wake-event line requests |
| wke_en | input | N_LINES | wake-event enables |
| kbd_irq | input | 1 | keyboard interrupt request |
| res_pin_n | input | 1 | reset pin, active low |
| stby_pin_n | input | 1 | hardware-standby pin, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | peripheral clock enable |
| osc_en | output | 1 | oscillator enable |
| unretained_rst | output | 1 | serial/PWM/converter units lose state |
| irq_take | output | 1 | one-cycle interrupt-handling request |
| core_rst_hold | output | 1 | core held in reset |
| hw_standby | output | 1 | hardware standby active |
| wake_src | output | 3 | accepted wake source code |

## Verification
All outputs decode from the state register, so every state change caused by an input shows on the outputs one clock edge after the edge that samples it. The bench drives on the falling edge and samples on the next falling edge, which places each check one edge after its stimulus. The stabilization time is measured by counting rising edges from the accepting edge until `irq_take` is seen; the count must equal N exactly. `irq_take` is checked again one edge later to confirm it has dropped. The bench uses `SCALE_SHIFT`=4 so that the long codes fit the run.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_SWSTBY   = 3'd1,
        ST_OSCWAIT  = 3'd2,
        ST_WAKEIRQ  = 3'd3,
        ST_RSTWAIT  = 3'd4,
        ST_HWSTBY   = 3'd5
    } pmu_state_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_NMI   = 3'd1,
        SRC_IRQ   = 3'd2,
        SRC_KEY   = 3'd3,
        SRC_WKE   = 3'd4,
        SRC_KBD   = 3'd5,
        SRC_RESET = 3'd6,
        SRC_HWPIN = 3'd7
    } wake_src_e;

    // Stabilization length in cycles for a select code, scaled down by a shift.
    function automatic int unsigned stab_cycles(input logic [2:0] sel,
                                                input int unsigned shift);
        int unsigned base;
        int unsigned scaled;
        if (sel <= 3'd5)
            base = 32'd1 << (13 + int'(sel));
        else if (sel == 3'd6)
            base = 32'd2048;
        else
            base = 32'd16;
        scaled = base >> shift;
        if (scaled == 0)
            scaled = 1;
        return scaled;
    endfunction

endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual
    import stby_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input  logic               cpu_irq_mask,
    input  logic               nmi,
    input  logic [N_LINES-1:0] irq_req,
    input  logic [N_LINES-1:0] irq_en,
    input  logic [N_LINES-1:0] key_in,
    input  logic [N_LINES-1:0] key_en,
    input  logic [N_LINES-1:0] wke_in,
    input  logic [N_LINES-1:0] wke_en,
    input  logic               kbd_irq,
    output logic               wake_hit,
    output wake_src_e          wake_code
);
    localparam int N_GRP = 3;  // IRQ, key input, wake event

    logic [N_GRP-1:0][N_LINES-1:0] grp_req;
    logic [N_GRP-1:0][N_LINES-1:0] grp_en;
    logic [N_GRP-1:0]              grp_hit;
    logic                          kbd_hit;

    assign grp_req[0] = irq_req;
    assign grp_en[0]  = irq_en;
    assign grp_req[1] = key_in;
    assign grp_en[1]  = key_en;
    assign grp_req[2] = wke_in;
    assign grp_en[2]  = wke_en;

    // Each grouped line must be requested, enabled and not masked.
    genvar g;
    generate
        for (g = 0; g < N_GRP; g++) begin : g_grp
            assign grp_hit[g] = (|(grp_req[g] & grp_en[g])) & ~cpu_irq_mask;
        end
    endgenerate

    assign kbd_hit = kbd_irq & ~cpu_irq_mask;

    always_comb begin
        wake_hit  = 1'b1;
        wake_code = SRC_NONE;
        if (nmi)
            wake_code = SRC_NMI;
        else if (grp_hit[0])
            wake_code = SRC_IRQ;
        else if (grp_hit[1])
            wake_code = SRC_KEY;
        else if (grp_hit[2])
            wake_code = SRC_WKE;
        else if (kbd_hit)
            wake_code = SRC_KBD;
        else
            wake_hit = 1'b0;
    end

endmodule

// File: rtl/stby_stab_cnt.sv
module stby_stab_cnt
    import stby_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [2:0] sel_i,
    input  logic       dec_i,
    output logic       zero_o
);
    // Code 5 is the longest setting for every shift value.
    localparam int unsigned MAX_CNT = stab_cycles(3'd5, SCALE_SHIFT);
    localparam int          CNT_W   = $clog2(MAX_CNT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CNT_W'(stab_cycles(sel_i, SCALE_SHIFT) - 1);
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_strobe,
    input  logic       sel_standby,
    input  logic       low_speed_on,
    input  logic       wdt_presc_sel,
    input  logic       wake_hit,
    input  wake_src_e  wake_code,
    input  logic       res_pin_n,
    input  logic       stby_pin_n,
    input  logic       cnt_zero,
    output logic       cnt_load,
    output logic       cnt_dec,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       unretained_rst,
    output logic       irq_take,
    output logic       core_rst_hold,
    output logic       hw_standby,
    output logic [2:0] wake_src
);
    pmu_state_e state_q, state_d;
    wake_src_e  src_q;
    logic       entry_ok;

    assign entry_ok = sleep_strobe & sel_standby & ~low_speed_on & ~wdt_presc_sel;

    // Next state: standby pin first, then reset pin, then normal flow.
    always_comb begin
        state_d = state_q;
        if (!stby_pin_n) begin
            state_d = ST_HWSTBY;
        end else if (state_q == ST_HWSTBY || !res_pin_n) begin
            state_d = ST_RSTWAIT;
        end else begin
            unique case (state_q)
                ST_RUN:     if (entry_ok) state_d = ST_SWSTBY;
                ST_SWSTBY:  if (wake_hit) state_d = ST_OSCWAIT;
                ST_OSCWAIT: if (cnt_zero) state_d = ST_WAKEIRQ;
                ST_WAKEIRQ: state_d = ST_RUN;
                ST_RSTWAIT: state_d = ST_RUN;
                ST_HWSTBY:  state_d = ST_HWSTBY;
                default:    state_d = ST_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // Accepted-source record, updated on state changes only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
        end else if (state_d != state_q) begin
            unique case (state_d)
                ST_SWSTBY:  src_q <= SRC_NONE;
                ST_OSCWAIT: src_q <= wake_code;
                ST_RSTWAIT: src_q <= SRC_RESET;
                ST_HWSTBY:  src_q <= SRC_HWPIN;
                default:    src_q <= src_q;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        cpu_clk_en     = 1'b0;
        per_clk_en     = 1'b0;
        osc_en         = 1'b0;
        unretained_rst = 1'b0;
        irq_take       = 1'b0;
        core_rst_hold  = 1'b0;
        hw_standby     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                osc_en     = 1'b1;
            end
            ST_SWSTBY: begin
                unretained_rst = 1'b1;
            end
            ST_OSCWAIT: begin
                osc_en         = 1'b1;
                unretained_rst = 1'b1;
            end
            ST_WAKEIRQ: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                osc_en     = 1'b1;
                irq_take   = 1'b1;
            end
            ST_RSTWAIT: begin
                cpu_clk_en     = 1'b1;
                per_clk_en     = 1'b1;
                osc_en         = 1'b1;
                unretained_rst = 1'b1;
                core_rst_hold  = 1'b1;
            end
            ST_HWSTBY: begin
                unretained_rst = 1'b1;
                hw_standby     = 1'b1;
            end
            default: ;
        endcase
    end

    assign cnt_load = (state_q == ST_SWSTBY) && (state_d == ST_OSCWAIT);
    assign cnt_dec  = (state_q == ST_OSCWAIT);
    assign wake_src = src_q;

    a_r1_no_entry_on_bad_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && res_pin_n && stby_pin_n &&
         !(sel_standby && !low_speed_on && !wdt_presc_sel)) |=> state_q == ST_RUN);

    a_r4_stay_asleep_without_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWSTBY && !wake_hit && res_pin_n && stby_pin_n) |=> state_q == ST_SWSTBY);

    a_r6_wait_follows_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSCWAIT && $past(state_q) != ST_OSCWAIT) |-> $past(state_q) == ST_SWSTBY);

    a_r7_take_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    a_r8_reset_pin_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_pin_n && !res_pin_n && state_q != ST_HWSTBY) |=> core_rst_hold);

    a_r9_hw_pin_first: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_pin_n |=> (hw_standby && !cpu_clk_en && !osc_en));

endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
    import stby_pkg::*;
#(
    parameter int          N_LINES     = 16,
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_strobe,
    input  logic               sel_standby,
    input  logic               low_speed_on,
    input  logic               wdt_presc_sel,
    input  logic [2:0]         stab_sel,
    input  logic               cpu_irq_mask,
    input  logic               nmi,
    input  logic [N_LINES-1:0] irq_req,
    input  logic [N_LINES-1:0] irq_en,
    input  logic [N_LINES-1:0] key_in,
    input  logic [N_LINES-1:0] key_en,
    input  logic [N_LINES-1:0] wke_in,
    input  logic [N_LINES-1:0] wke_en,
    input  logic               kbd_irq,
    input  logic               res_pin_n,
    input  logic               stby_pin_n,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               osc_en,
    output logic               unretained_rst,
    output logic               irq_take,
    output logic               core_rst_hold,
    output logic               hw_standby,
    output logic [2:0]         wake_src
);
    logic      wake_hit;
    wake_src_e wake_code;
    logic      cnt_load;
    logic      cnt_dec;
    logic      cnt_zero;

    stby_wake_qual #(.N_LINES(N_LINES)) u_qual (
        .cpu_irq_mask (cpu_irq_mask),
        .nmi          (nmi),
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .key_in       (key_in),
        .key_en       (key_en),
        .wke_in       (wke_in),
        .wke_en       (wke_en),
        .kbd_irq      (kbd_irq),
        .wake_hit     (wake_hit),
        .wake_code    (wake_code)
    );

    stby_stab_cnt #(.SCALE_SHIFT(SCALE_SHIFT)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .sel_i  (stab_sel),
        .dec_i  (cnt_dec),
        .zero_o (cnt_zero)
    );

    stby_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_strobe   (sleep_strobe),
        .sel_standby    (sel_standby),
        .low_speed_on   (low_speed_on),
        .wdt_presc_sel  (wdt_presc_sel),
        .wake_hit       (wake_hit),
        .wake_code      (wake_code),
        .res_pin_n      (res_pin_n),
        .stby_pin_n     (stby_pin_n),
        .cnt_zero       (cnt_zero),
        .cnt_load       (cnt_load),
        .cnt_dec        (cnt_dec),
        .cpu_clk_en     (cpu_clk_en),
        .per_clk_en     (per_clk_en),
        .osc_en         (osc_en),
        .unretained_rst (unretained_rst),
        .irq_take       (irq_take),
        .core_rst_hold  (core_rst_hold),
        .hw_standby     (hw_standby),
        .wake_src       (wake_src)
    );

endmodule

// File: tb/stby_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module stby_pwr_ctrl_bench;
    localparam int          NL    = 16;
    localparam int unsigned SHIFT = 4;
    localparam int          NVEC  = 12;

    // Vector: [12]mask [11]nmi [10]irq [9]irq_en [8]key [7]key_en
    //         [6]wke [5]wke_en [4]kbd [3]expect_wake [2:0]expect_src
    localparam logic [12:0] VEC [NVEC] = '{
        13'b0011000001010,  // irq enabled, unmasked -> 2
        13'b0010000000000,  // irq line not enabled
        13'b1011000000000,  // irq masked
        13'b1100000001001,  // nmi ignores mask -> 1
        13'b0000110001011,  // key enabled -> 3
        13'b0000100000000,  // key not enabled
        13'b0000001101100,  // wake event enabled -> 4
        13'b1000001100000,  // wake event masked
        13'b0000000011101,  // keyboard -> 5
        13'b1000000010000,  // keyboard masked
        13'b0111000001001,  // nmi beats irq -> 1
        13'b0011110001010   // irq beats key -> 2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_strobe = 0, sel_standby = 1, low_speed_on = 0, wdt_presc_sel = 0;
    logic [2:0] stab_sel = 3'd7;
    logic cpu_irq_mask = 0, nmi = 0, kbd_irq = 0;
    logic [NL-1:0] irq_req = '0, irq_en = '0, key_in = '0, key_en = '0, wke_in = '0, wke_en = '0;
    logic res_pin_n = 1, stby_pin_n = 1;
    logic cpu_clk_en, per_clk_en, osc_en, unretained_rst, irq_take, core_rst_hold, hw_standby;
    logic [2:0] wake_src;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    stby_pwr_ctrl #(.N_LINES(NL), .SCALE_SHIFT(SHIFT)) u_stby_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .sel_standby(sel_standby),
        .low_speed_on(low_speed_on), .wdt_presc_sel(wdt_presc_sel), .stab_sel(stab_sel),
        .cpu_irq_mask(cpu_irq_mask), .nmi(nmi), .irq_req(irq_req), .irq_en(irq_en),
        .key_in(key_in), .key_en(key_en), .wke_in(wke_in), .wke_en(wke_en), .kbd_irq(kbd_irq),
        .res_pin_n(res_pin_n), .stby_pin_n(stby_pin_n), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .unretained_rst(unretained_rst),
        .irq_take(irq_take), .core_rst_hold(core_rst_hold), .hw_standby(hw_standby),
        .wake_src(wake_src)
    );

    function automatic int exp_cycles(input logic [2:0] s);
        int base;
        case (s)
            3'd0: base = 8192;
            3'd1: base = 16384;
            3'd2: base = 32768;
            3'd3: base = 65536;
            3'd4: base = 131072;
            3'd5: base = 262144;
            3'd6: base = 2048;
            default: base = 16;
        endcase
        base = base >> SHIFT;
        return (base < 1) ? 1 : base;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_wake();
        nmi = 0; kbd_irq = 0; cpu_irq_mask = 0;
        irq_req = '0; irq_en = '0; key_in = '0; key_en = '0; wke_in = '0; wke_en = '0;
    endtask

    task automatic enter_standby();
        sel_standby = 1; low_speed_on = 0; wdt_presc_sel = 0;
        sleep_strobe = 1;
        step();
        sleep_strobe = 0;
    endtask

    task automatic wait_take(output int n);
        n = 0;
        while (!irq_take && n < 20000) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state (R2, R3, R10)
        chk("R2 reset cpu_clk_en", cpu_clk_en, 1);
        chk("R2 reset osc_en", osc_en, 1);
        chk("R3 reset unretained_rst", unretained_rst, 0);
        chk("R10 reset wake_src", wake_src, 0);
        chk("R7 reset irq_take", irq_take, 0);

        // R1: each wrong bit keeps the block running
        sel_standby = 0; sleep_strobe = 1; step(); sleep_strobe = 0;
        chk("R1 sel_standby=0 stays running", cpu_clk_en, 1);
        sel_standby = 1; low_speed_on = 1; sleep_strobe = 1; step(); sleep_strobe = 0;
        chk("R1 low_speed_on=1 stays running", cpu_clk_en, 1);
        low_speed_on = 0; wdt_presc_sel = 1; sleep_strobe = 1; step(); sleep_strobe = 0;
        chk("R1 wdt_presc_sel=1 stays running", cpu_clk_en, 1);
        wdt_presc_sel = 0; step();
        chk("R1 no strobe stays running", cpu_clk_en, 1);

        // R1/R2/R3: correct entry
        enter_standby();
        chk("R1 entry cpu_clk_en", cpu_clk_en, 0);
        chk("R2 standby per_clk_en", per_clk_en, 0);
        chk("R2 standby osc_en", osc_en, 0);
        chk("R3 standby unretained_rst", unretained_rst, 1);
        chk("R10 standby wake_src cleared", wake_src, 0);
        step();
        chk("R2 standby holds", cpu_clk_en, 0);
        nmi = 1; step(); nmi = 0;
        wait_take(n);
        step();

        // R4/R5/R10: wake vector table
        stab_sel = 3'd7;
        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            enter_standby();
            cpu_irq_mask = v[12];
            nmi          = v[11];
            irq_req      = v[10] ? 16'h0020 : 16'h0000;
            irq_en       = v[9]  ? 16'h0020 : 16'hFFDF;
            key_in       = v[8]  ? 16'h0400 : 16'h0000;
            key_en       = v[7]  ? 16'h0400 : 16'hFBFF;
            wke_in       = v[6]  ? 16'h8000 : 16'h0000;
            wke_en       = v[5]  ? 16'h8000 : 16'h7FFF;
            kbd_irq      = v[4];
            step();
            chk($sformatf("R4 R5 vector %0d osc_en", i), osc_en, int'(v[3]));
            if (v[3]) begin
                chk($sformatf("R10 vector %0d wake_src", i), wake_src, int'(v[2:0]));
                clear_wake();
                wait_take(n);
                chk($sformatf("R6 vector %0d wait length", i), n, 1);
                step();
            end else begin
                step();
                chk($sformatf("R4 R5 vector %0d still asleep", i), cpu_clk_en, 0);
                clear_wake();
                nmi = 1; step(); nmi = 0;
                wait_take(n);
                step();
            end
            chk($sformatf("R7 vector %0d back in run", i), cpu_clk_en, 1);
        end

        // R6/R7: stabilization length for several codes
        foreach (VEC[j]) begin
            if (j < 4) begin
                logic [2:0] code;
                code = (j == 0) ? 3'd7 : (j == 1) ? 3'd6 : (j == 2) ? 3'd0 : 3'd2;
                stab_sel = code;
                enter_standby();
                kbd_irq = 1; step(); kbd_irq = 0;
                chk("R6 wait osc_en", osc_en, 1);
                chk("R6 wait cpu_clk_en", cpu_clk_en, 0);
                chk("R3 wait unretained_rst", unretained_rst, 1);
                wait_take(n);
                chk($sformatf("R6 code %0d length", code), n, exp_cycles(code));
                chk("R7 take with clocks", cpu_clk_en, 1);
                chk("R3 wake unretained_rst", unretained_rst, 0);
                step();
                chk("R7 take single cycle", irq_take, 0);
                chk("R7 running after take", cpu_clk_en, 1);
            end
        end

        // R8: reset pin during standby
        enter_standby();
        res_pin_n = 0; step();
        chk("R8 reset hold", core_rst_hold, 1);
        chk("R8 reset cpu clock", cpu_clk_en, 1);
        chk("R8 reset per clock", per_clk_en, 1);
        chk("R10 reset src", wake_src, 6);
        repeat (3) step();
        chk("R8 reset still held", core_rst_hold, 1);
        res_pin_n = 1; step();
        chk("R8 released hold", core_rst_hold, 0);
        chk("R8 released run", unretained_rst, 0);

        // R11: reset pin aborts the stabilization wait
        stab_sel = 3'd0;
        enter_standby();
        nmi = 1; step(); nmi = 0;
        repeat (10) step();
        chk("R11 still waiting", osc_en, 1);
        res_pin_n = 0; step();
        chk("R11 abort to reset", core_rst_hold, 1);
        chk("R11 no take", irq_take, 0);
        res_pin_n = 1;
        n = 0;
        for (int k = 0; k < 600; k++) begin
            step();
            if (irq_take) n++;
        end
        chk("R11 no take after abort", n, 0);

        // R9: standby pin beats reset pin
        enter_standby();
        res_pin_n = 0; stby_pin_n = 0; step();
        chk("R9 hw standby", hw_standby, 1);
        chk("R9 hw clocks off", cpu_clk_en, 0);
        chk("R9 hw osc off", osc_en, 0);
        chk("R9 hw not reset", core_rst_hold, 0);
        chk("R10 hw src", wake_src, 7);
        res_pin_n = 1; step();
        chk("R9 hw holds", hw_standby, 1);
        stby_pin_n = 1; step();
        chk("R9 leave to reset wait", core_rst_hold, 1);
        chk("R9 left hw", hw_standby, 0);
        step();
        chk("R9 back to run", cpu_clk_en, 1);

        // R9: from RUN
        stby_pin_n = 0; step();
        chk("R9 from run", hw_standby, 1);
        stby_pin_n = 1; step(); step();
        chk("R9 run restored", cpu_clk_en, 1);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule